// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the sequencing core of an on-chip clock generator. It decides which of five operating conditions the generator is in: powered down, running on its own free-running oscillator, locking the loop to an internal reference, passing an external clock straight through, or locking the loop to that external clock. Software picks the wanted condition through a 2-bit select field and a write strobe. A stop request powers the generator down. Three flags from the analog side steer the sequencing: the oscillator has settled, the loop is in lock, and the external reference has vanished. The oscillator, the loop filter arithmetic and the analog circuits are not part of this block.

When the generator leaves the powered-down state with a loop-locking selection, the controller first parks on the free-running oscillator. It waits there until that oscillator reports stable, and then closes the loop without any further software action. If the external reference disappears while it is in use, the controller falls back to the free-running oscillator by itself. It then raises a sticky interrupt flag or, when enabled, a one-cycle reset request. A hold flag tells the frequency logic whether to keep its last setting or to return to the nominal default. While the loop uses the internal reference, a divider produces one reference tick every `REF_DIV` cycles.

All pins are plain control and status signals. There is no data stream and no valid/ready handshake, so back-pressure does not apply.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` reads 00, and `off_o`, `loop_closed_o`, `freq_hold_o`, `irq_o` and `rst_req_o` are all 0.
- R2: While `stop_i` is high at a rising edge, the controller is powered down from the next cycle on. In that state `off_o`=1, `mode_o` reads 00 and `loop_closed_o`=0.
- R3: On the first edge with `stop_i` low while powered down, if the stored select is 01 or 11, the controller enters mode 00. It stays there for as long as `dco_stable_i` is low and no write occurs.
- R4: In that waiting state, the first edge with `dco_stable_i` high moves the controller to the stored select (01 or 11) with `loop_closed_o`=1, and no write is needed.
- R5: On leaving the powered-down state with a stored select of 00 or 10, the controller goes directly to that mode.
- R6: A write (`sel_wr_i`=1) sets the mode from the next cycle. The encoding is 00 free-running, 01 loop on internal reference, 10 external bypass and 11 loop on external reference. `mode_o` uses the same encoding, and `loop_closed_o` is 1 exactly in modes 01 and 11. Priority is stop, then leaving power-down, then reference loss, then write, then pending loop closure.
- R7: When `ref_lost_i` is high in mode 10 or 11, the next cycle shows mode 00. In modes 00 and 01, `ref_lost_i` is ignored: the mode is unchanged and no flag is raised.
- R8: `freq_hold_o` is 1 after mode 00 is entered from mode 01 or 11 (by a write or by reference loss) or from power-down. It is 0 in modes 01, 10 and 11, and after reset.
- R9: A reference-loss fallback with `loss_rst_en_i`=0 sets `irq_o`. The flag stays set until a `flag_clr_i` pulse clears it, and a set in the same cycle wins over the clear.
- R10: With `loss_rst_en_i`=1, a reference-loss fallback produces a one-cycle `rst_req_o` pulse and leaves `irq_o` unchanged.
- R11: `ref_tick_o` pulses once every `REF_DIV` (default 7) cycles while in mode 01, and never in any other mode.
- R12: `loop_locked_o` is 1 exactly when `loop_closed_o` is 1 and `lock_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Requested mode select |
| sel_wr_i | input | 1 | Write strobe for `sel_i` |
| stop_i | input | 1 | Power-down request, level |
| dco_stable_i | input | 1 | Free-running oscillator has settled |
| lock_i | input | 1 | Loop reports lock |
| ref_lost_i | input | 1 | External reference has been lost |
| flag_clr_i | input | 1 | Write-one-to-clear for `irq_o` |
| loss_rst_en_i | input | 1 | Turn reference loss into a reset request |
| mode_o | output | 2 | Current mode, same encoding as `sel_i` |
| off_o | output | 1 | Generator powered down |
| loop_closed_o | output | 1 | Loop is engaged (mode 01 or 11) |
| loop_locked_o | output | 1 | Loop engaged and in lock |
| freq_hold_o | output | 1 | Keep last frequency setting (1) or use default (0) |
| irq_o | output | 1 | Sticky reference-loss interrupt |
| rst_req_o | output | 1 | One-cycle reset request on reference loss |
| ref_tick_o | output | 1 | Divided internal reference tick |

## Verification
Every mode, hold, interrupt and reset-request result is registered and appears one rising edge after the stimulus is sampled. `loop_locked_o` and `ref_tick_o` are decoded from registered state, so they are valid in the same cycle as that state. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, which places every check one full edge after its cause. Tick rates are measured by counting pulses over a window of a whole number of `REF_DIV` periods, so the result does not depend on the counter's phase.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SELF       = 2'b00,
    MODE_LOOP_INT   = 2'b01,
    MODE_BYPASS_EXT = 2'b10,
    MODE_LOOP_EXT   = 2'b11
  } clk_mode_e;

  // bit 1 set: external clock in use; bit 0 set: loop engaged
  function automatic logic mode_is_ext(clk_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_loop(clk_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
  import clkgen_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       sel_wr_i,
  input  logic       stop_i,
  input  logic       dco_stable_i,
  input  logic       ref_lost_i,
  output clk_mode_e  mode_o,
  output logic       off_o,
  output logic       hold_o,
  output logic       lost_evt_o
);
  clk_mode_e mode_q, mode_d;
  logic [1:0] sel_q, sel_d;
  logic       off_q, off_d;
  logic       pend_q, pend_d;
  logic       hold_q, hold_d;

  always_comb begin
    mode_d     = mode_q;
    off_d      = off_q;
    pend_d     = pend_q;
    hold_d     = hold_q;
    sel_d      = sel_wr_i ? sel_i : sel_q;
    lost_evt_o = 1'b0;
    if (stop_i) begin
      off_d  = 1'b1;
      pend_d = 1'b0;
    end else if (off_q) begin
      off_d = 1'b0;
      if (sel_d[0]) begin
        // loop selection: run free until the oscillator settles
        mode_d = MODE_SELF;
        pend_d = 1'b1;
        hold_d = 1'b1;
      end else begin
        mode_d = clk_mode_e'(sel_d);
        pend_d = 1'b0;
        hold_d = (clk_mode_e'(sel_d) == MODE_SELF);
      end
    end else if (ref_lost_i && mode_is_ext(mode_q)) begin
      mode_d     = MODE_SELF;
      pend_d     = 1'b0;
      hold_d     = 1'b1;
      lost_evt_o = 1'b1;
    end else if (sel_wr_i) begin
      mode_d = clk_mode_e'(sel_i);
      pend_d = 1'b0;
      hold_d = (clk_mode_e'(sel_i) == MODE_SELF) ? (hold_q | mode_is_loop(mode_q)) : 1'b0;
    end else if (pend_q && dco_stable_i) begin
      mode_d = clk_mode_e'(sel_q);
      pend_d = 1'b0;
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SELF;
      sel_q  <= 2'b00;
      off_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      off_q  <= off_d;
      pend_q <= pend_d;
      hold_q <= hold_d;
    end
  end

  assign mode_o = off_q ? MODE_SELF : mode_q;
  assign off_o  = off_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/clkgen_ref_div.sv
module clkgen_ref_div #(
  parameter int unsigned REF_DIV = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/clkgen_loss_flag.sv
module clkgen_loss_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lost_evt_i,
  input  logic rst_en_i,
  input  logic clr_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic irq_q, req_q;
  logic set_irq;

  assign set_irq = lost_evt_i && !rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (set_irq)    irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
      req_q <= lost_evt_i && rst_en_i;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_mode_pkg::*;
#(
  parameter int unsigned REF_DIV = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       sel_wr_i,
  input  logic       stop_i,
  input  logic       dco_stable_i,
  input  logic       lock_i,
  input  logic       ref_lost_i,
  input  logic       flag_clr_i,
  input  logic       loss_rst_en_i,
  output logic [1:0] mode_o,
  output logic       off_o,
  output logic       loop_closed_o,
  output logic       loop_locked_o,
  output logic       freq_hold_o,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       ref_tick_o
);
  clk_mode_e mode;
  logic      off, lost_evt;

  clkgen_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_i),
    .sel_wr_i     (sel_wr_i),
    .stop_i       (stop_i),
    .dco_stable_i (dco_stable_i),
    .ref_lost_i   (ref_lost_i),
    .mode_o       (mode),
    .off_o        (off),
    .hold_o       (freq_hold_o),
    .lost_evt_o   (lost_evt)
  );

  clkgen_loss_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lost_evt_i (lost_evt),
    .rst_en_i   (loss_rst_en_i),
    .clr_i      (flag_clr_i),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );

  clkgen_ref_div #(.REF_DIV(REF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!off && (mode == MODE_LOOP_INT)),
    .tick_o (ref_tick_o)
  );

  assign mode_o        = mode;
  assign off_o         = off;
  assign loop_closed_o = !off && mode_is_loop(mode);
  assign loop_locked_o = loop_closed_o && lock_i;
endmodule

// File: rtl/clkgen_mode_chk.sv
module clkgen_mode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] sel_i,
  input logic       sel_wr_i,
  input logic       stop_i,
  input logic       ref_lost_i,
  input logic [1:0] mode_o,
  input logic       off_o,
  input logic       loop_closed_o,
  input logic       freq_hold_o,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       ref_tick_o
);
  assert_stop_powers_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (off_o && mode_o == 2'b00 && !loop_closed_o));

  assert_write_sets_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_o && sel_wr_i && !stop_i && !(ref_lost_i && mode_o[1])) |=> (mode_o == $past(sel_i)));

  assert_loss_falls_back_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_o && mode_o[1] && ref_lost_i && !stop_i) |=> (mode_o == 2'b00 && freq_hold_o));

  assert_no_hold_outside_self_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_o && mode_o != 2'b00) |-> !freq_hold_o);

  assert_irq_needs_loss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ref_lost_i));

  assert_req_excludes_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$rose(irq_o));

  assert_tick_only_internal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tick_o |-> (!off_o && mode_o == 2'b01));
endmodule

bind clkgen_mode_ctrl clkgen_mode_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_i         (sel_i),
  .sel_wr_i      (sel_wr_i),
  .stop_i        (stop_i),
  .ref_lost_i    (ref_lost_i),
  .mode_o        (mode_o),
  .off_o         (off_o),
  .loop_closed_o (loop_closed_o),
  .freq_hold_o   (freq_hold_o),
  .irq_o         (irq_o),
  .rst_req_o     (rst_req_o),
  .ref_tick_o    (ref_tick_o)
);

// File: tb/clkgen_mode_ctrl_tb.sv
module clkgen_mode_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DIV = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       sel_wr = 1'b0, stop = 1'b0, dco_ok = 1'b0, lock = 1'b0;
  logic       ref_lost = 1'b0, clr = 1'b0, rst_en = 1'b0;
  logic [1:0] mode;
  logic       off, closed, locked, hold, irq, rst_req, tick;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_mode_ctrl #(.REF_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sel_wr_i(sel_wr), .stop_i(stop),
    .dco_stable_i(dco_ok), .lock_i(lock), .ref_lost_i(ref_lost), .flag_clr_i(clr),
    .loss_rst_en_i(rst_en), .mode_o(mode), .off_o(off), .loop_closed_o(closed),
    .loop_locked_o(locked), .freq_hold_o(hold), .irq_o(irq), .rst_req_o(rst_req),
    .ref_tick_o(tick)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] v);
    sel = v; sel_wr = 1'b1; cyc(); sel_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);   chk("R1 off", off, 0);
    chk("R1 closed", closed, 0); chk("R1 hold", hold, 0);
    chk("R1 irq", irq, 0);     chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_writes();
    wr(2'b01);
    chk("R6 mode 01", mode, 1); chk("R6 closed 01", closed, 1); chk("R8 hold in 01", hold, 0);
    lock = 1'b1; cyc(); chk("R12 locked", locked, 1);
    lock = 1'b0; cyc(); chk("R12 unlocked", locked, 0);
    wr(2'b10);
    chk("R6 mode 10", mode, 2); chk("R6 closed 10", closed, 0);
    lock = 1'b1; cyc(); chk("R12 bypass not locked", locked, 0); lock = 1'b0;
    wr(2'b11);
    chk("R6 mode 11", mode, 3); chk("R6 closed 11", closed, 1);
    wr(2'b00);
    chk("R6 mode 00", mode, 0); chk("R8 hold from 11", hold, 1);
  endtask

  task automatic t_ref_div();
    int n;
    wr(2'b01);
    n = 0;
    for (int i = 0; i < 10*DIV; i++) begin cyc(); if (tick) n++; end
    chk("R11 ticks in 01", n, 10);
    wr(2'b00);
    n = 0;
    for (int i = 0; i < 10*DIV; i++) begin cyc(); if (tick) n++; end
    chk("R11 ticks in 00", n, 0);
  endtask

  task automatic t_off_wait();
    wr(2'b11);
    stop = 1'b1; cyc();
    chk("R2 off", off, 1); chk("R2 mode", mode, 0); chk("R2 closed", closed, 0);
    cyc(); cyc(); chk("R2 still off", off, 1);
    stop = 1'b0; cyc();
    chk("R3 left off", off, 0); chk("R3 parked", mode, 0); chk("R8 hold from off", hold, 1);
    for (int i = 0; i < 5; i++) cyc();
    chk("R3 still parked", mode, 0); chk("R3 open", closed, 0);
    dco_ok = 1'b1; cyc(); dco_ok = 1'b0;
    chk("R4 auto close", mode, 3); chk("R4 closed", closed, 1); chk("R8 hold cleared", hold, 0);
  endtask

  task automatic t_off_direct();
    wr(2'b10);
    stop = 1'b1; cyc(); stop = 1'b0; cyc();
    chk("R5 direct 10", mode, 2); chk("R5 on", off, 0);
    wr(2'b00);
    stop = 1'b1; cyc(); stop = 1'b0; cyc();
    chk("R5 direct 00", mode, 0);
  endtask

  task automatic t_loss();
    wr(2'b11);
    ref_lost = 1'b1; cyc(); ref_lost = 1'b0;
    chk("R7 fallback", mode, 0); chk("R8 hold on loss", hold, 1); chk("R9 irq set", irq, 1);
    cyc(); cyc(); chk("R9 irq sticky", irq, 1);
    clr = 1'b1; cyc(); clr = 1'b0; chk("R9 irq cleared", irq, 0);
    wr(2'b01);
    ref_lost = 1'b1; cyc(); ref_lost = 1'b0;
    chk("R7 ignored in 01 mode", mode, 1); chk("R7 ignored in 01 irq", irq, 0);
    wr(2'b10);
    ref_lost = 1'b1; clr = 1'b1; cyc(); ref_lost = 1'b0; clr = 1'b0;
    chk("R7 fallback from 10", mode, 0); chk("R9 set beats clear", irq, 1);
    clr = 1'b1; cyc(); clr = 1'b0;
  endtask

  task automatic t_loss_reset();
    rst_en = 1'b1;
    wr(2'b11);
    ref_lost = 1'b1; cyc(); ref_lost = 1'b0;
    chk("R10 rst_req", rst_req, 1); chk("R10 irq untouched", irq, 0); chk("R10 mode", mode, 0);
    cyc(); chk("R10 one cycle", rst_req, 0);
    rst_en = 1'b0;
  endtask

  task automatic t_priority();
    wr(2'b11);
    sel = 2'b01; sel_wr = 1'b1; ref_lost = 1'b1; cyc(); sel_wr = 1'b0; ref_lost = 1'b0;
    chk("R6 loss beats write", mode, 0);
    clr = 1'b1; cyc(); clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_writes();
    t_ref_div();
    t_off_wait();
    t_off_direct();
    t_loss();
    t_loss_reset();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule